// File: doc/BRIEF.md
# Total-Store-Order Write Buffer with Read Forwarding

This block sits between one hardware thread and the shared memory port. Every store the thread makes is held here first, in arrival order. The thread can store without waiting for any other thread. A load first looks at the held stores. If one or more of them target the same address, the load gets the value of the most recent one, in the same cycle. If none of them match, the load reads shared memory. Held stores are written to memory one per cycle, oldest first.

A fence request from the thread is acknowledged only when no stores remain held. The block also watches a global lock. When a different thread owns that lock, this thread is blocked: its loads and its writes to memory wait until the lock is released or passes to this thread. Stores may still be taken into the buffer while blocked.

Top module: `tso_wbuf`

## Requirements
- R1: After reset the buffer is empty: `empty_o` is 1 and `mem_wr_valid_o` is 0.
- R2: A write request (`req_op_i` = 1) is accepted in any cycle in which the buffer is not full. It becomes the newest entry and `empty_o` falls in the next cycle.
- R3: When all `DEPTH` entries are in use, a write request sees `req_ready_o` = 0 and is held off until a drain frees a slot. The occupancy never exceeds `DEPTH`.
- R4: A read request (`req_op_i` = 0) whose address matches one or more buffered entries returns the data of the newest matching entry on `rd_data_o`, with `req_ready_o` = 1 in the same cycle.
- R5: A read request that matches no buffered entry returns `mem_rd_data_i`, with `mem_rd_addr_o` equal to the request address.
- R6: Entries leave the buffer strictly oldest first, one per accepted memory write (`mem_wr_valid_o` and `mem_wr_ready_i` both 1). The address and data of each leaving entry are presented on `mem_wr_addr_o` and `mem_wr_data_o`.
- R7: While `mem_wr_ready_i` is 0, the presented drain address and data stay unchanged and no entry is removed.
- R8: While `lock_held_i` is 1 and `lock_owner_i` differs from `SELF_TID`, `mem_wr_valid_o` is 0 and read requests see `req_ready_o` = 0.
- R9: While this thread owns the lock (`lock_owner_i` = `SELF_TID`), reads and drains proceed as if the lock were free.
- R10: A fence request (`req_op_i` = 2) sees `req_ready_o` = 1 only in a cycle in which the buffer is empty.
- R11: `empty_o` is 1 exactly when the buffer holds no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Thread request valid |
| req_op_i | input | 2 | Operation: 0 read, 1 write, 2 fence |
| req_addr_i | input | ADDR_W | Request address |
| req_wdata_i | input | DATA_W | Write data |
| req_ready_o | output | 1 | Request completes this cycle |
| rd_data_o | output | DATA_W | Read result, valid with a completing read |
| mem_rd_en_o | output | 1 | Memory read strobe for an unforwarded read |
| mem_rd_addr_o | output | ADDR_W | Memory read address |
| mem_rd_data_i | input | DATA_W | Memory read data, same cycle |
| mem_wr_valid_o | output | 1 | Drain write valid |
| mem_wr_addr_o | output | ADDR_W | Drain write address |
| mem_wr_data_o | output | DATA_W | Drain write data |
| mem_wr_ready_i | input | 1 | Memory accepts the drain write |
| lock_held_i | input | 1 | Global lock is taken |
| lock_owner_i | input | TID_W | Thread that owns the global lock |
| empty_o | output | 1 | Buffer holds no entry |

## Verification
The assertions assume that memory answers reads combinationally in the same cycle, and that the lock inputs change only between clock edges. They also assume the thread holds a request stable until `req_ready_o` is seen. The stimulus drives every input just after a rising edge and samples just before the next one. It keeps each request up until it completes or is withdrawn on purpose. It moves the lock owner between this thread, another thread and none, with drains both stalled and enabled. Buffered stores that share an address check that forwarding picks the newest one.

// File: rtl/tso_wbuf_pkg.sv
package tso_wbuf_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_FENCE = 2'd2
  } req_op_e;
endpackage

// File: rtl/tso_wbuf_fifo.sv
module tso_wbuf_fifo #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [ADDR_W-1:0] slot_addr_o [DEPTH],
  output logic [DATA_W-1:0] slot_data_o [DEPTH],
  output logic [PTR_W-1:0]  head_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              full_o,
  output logic              empty_o
);
  logic [PTR_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] count_q;
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];

  function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (push_i) tail_q <= wrap_inc(tail_q);
      if (pop_i)  head_q <= wrap_inc(head_q);
      if (push_i && !pop_i)      count_q <= count_q + 1'b1;
      else if (pop_i && !push_i) count_q <= count_q - 1'b1;
    end
  end

  for (genvar j = 0; j < DEPTH; j++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (push_i && tail_q == PTR_W'(j)) begin
        addr_q[j] <= push_addr_i;
        data_q[j] <= push_data_i;
      end
    end
    assign slot_addr_o[j] = addr_q[j];
    assign slot_data_o[j] = data_q[j];
  end

  assign head_o  = head_q;
  assign count_o = count_q;
  assign full_o  = (count_q == CNT_W'(DEPTH));
  assign empty_o = (count_q == '0);

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH));
  assert_push_fills_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> !empty_o);
  assert_pop_shrinks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i) |=> (count_o == $past(count_o) - 1'b1));
endmodule

// File: rtl/tso_wbuf_fwd.sv
module tso_wbuf_fwd #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int AGE_W = PTR_W + 2
) (
  input  logic [ADDR_W-1:0] slot_addr_i [DEPTH],
  input  logic [DATA_W-1:0] slot_data_i [DEPTH],
  input  logic [PTR_W-1:0]  head_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [ADDR_W-1:0] look_addr_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] hit_data_o
);
  logic [DEPTH-1:0] live_match;
  logic [AGE_W-1:0] age [DEPTH];

  // age 0 = oldest; a slot is live when its age is below the occupancy
  for (genvar j = 0; j < DEPTH; j++) begin : g_cmp
    always_comb begin
      if (PTR_W'(j) >= head_i) age[j] = AGE_W'(j) - AGE_W'(head_i);
      else                     age[j] = AGE_W'(j) + AGE_W'(DEPTH) - AGE_W'(head_i);
    end
    assign live_match[j] = (age[j] < AGE_W'(count_i)) && (slot_addr_i[j] == look_addr_i);
  end

  always_comb begin
    logic [AGE_W-1:0] best_age;
    hit_o      = 1'b0;
    hit_data_o = '0;
    best_age   = '0;
    for (int j = 0; j < DEPTH; j++) begin
      if (live_match[j] && (!hit_o || age[j] > best_age)) begin
        hit_o      = 1'b1;
        hit_data_o = slot_data_i[j];
        best_age   = age[j];
      end
    end
  end
endmodule

// File: rtl/tso_wbuf.sv
module tso_wbuf
  import tso_wbuf_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter int TID_W    = 2,
  parameter int SELF_TID = 1,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              mem_rd_en_o,
  output logic [ADDR_W-1:0] mem_rd_addr_o,
  input  logic [DATA_W-1:0] mem_rd_data_i,
  output logic              mem_wr_valid_o,
  output logic [ADDR_W-1:0] mem_wr_addr_o,
  output logic [DATA_W-1:0] mem_wr_data_o,
  input  logic              mem_wr_ready_i,
  input  logic              lock_held_i,
  input  logic [TID_W-1:0]  lock_owner_i,
  output logic              empty_o
);
  logic [ADDR_W-1:0] slot_addr [DEPTH];
  logic [DATA_W-1:0] slot_data [DEPTH];
  logic [PTR_W-1:0]  head;
  logic [CNT_W-1:0]  count;
  logic full, empty, push, pop, blocked, hit;
  logic [DATA_W-1:0] hit_data;
  req_op_e op;

  assign op      = req_op_e'(req_op_i);
  assign blocked = lock_held_i && (lock_owner_i != TID_W'(SELF_TID));
  assign push    = req_valid_i && (op == OP_WRITE) && !full;
  assign pop     = mem_wr_valid_o && mem_wr_ready_i;

  tso_wbuf_fifo #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fifo (
    .clk_i, .rst_ni,
    .push_i(push), .push_addr_i(req_addr_i), .push_data_i(req_wdata_i),
    .pop_i(pop),
    .slot_addr_o(slot_addr), .slot_data_o(slot_data),
    .head_o(head), .count_o(count), .full_o(full), .empty_o(empty)
  );

  tso_wbuf_fwd #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fwd (
    .slot_addr_i(slot_addr), .slot_data_i(slot_data),
    .head_i(head), .count_i(count), .look_addr_i(req_addr_i),
    .hit_o(hit), .hit_data_o(hit_data)
  );

  always_comb begin
    unique case (op)
      OP_READ:  req_ready_o = req_valid_i && !blocked;
      OP_WRITE: req_ready_o = req_valid_i && !full;
      OP_FENCE: req_ready_o = req_valid_i && empty;
      default:  req_ready_o = 1'b0;
    endcase
  end

  assign rd_data_o      = hit ? hit_data : mem_rd_data_i;
  assign mem_rd_en_o    = req_valid_i && (op == OP_READ) && !blocked && !hit;
  assign mem_rd_addr_o  = req_addr_i;
  assign mem_wr_valid_o = !empty && !blocked;
  assign mem_wr_addr_o  = slot_addr[head];
  assign mem_wr_data_o  = slot_data[head];
  assign empty_o        = empty;

  assert_drain_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_held_i && lock_owner_i != TID_W'(SELF_TID)) |-> !mem_wr_valid_o);
  assert_read_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_op_i == 2'd0 && lock_held_i && lock_owner_i != TID_W'(SELF_TID))
      |-> !req_ready_o);
  assert_fence_empty_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_op_i == 2'd2 && req_ready_o) |-> empty_o);
  assert_drain_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_valid_o && !mem_wr_ready_i) |=> ($stable(mem_wr_addr_o) && $stable(mem_wr_data_o) && !empty_o));
  assert_own_lock_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_owner_i == TID_W'(SELF_TID) && !empty_o) |-> mem_wr_valid_o);
endmodule

// File: tb/tso_wbuf_test.sv
`timescale 1ns/1ps
module tso_wbuf_test;
  localparam int DEPTH = 8, AW = 8, DW = 16, TW = 2, SELF = 1, OTHER = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, mem_rd_en, mem_wr_valid, empty;
  logic [DW-1:0] rd_data, mem_rd_data, mem_wr_data;
  logic [AW-1:0] mem_rd_addr, mem_wr_addr;
  logic mem_wr_ready = 1'b0, lock_held = 1'b0;
  logic [TW-1:0] lock_owner = '0;

  logic [DW-1:0] mem [256];
  logic [AW+DW-1:0] exp_q [$];
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tso_wbuf #(.DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW), .TID_W(TW), .SELF_TID(SELF)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_op_i(req_op), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .req_ready_o(req_ready), .rd_data_o(rd_data),
    .mem_rd_en_o(mem_rd_en), .mem_rd_addr_o(mem_rd_addr), .mem_rd_data_i(mem_rd_data),
    .mem_wr_valid_o(mem_wr_valid), .mem_wr_addr_o(mem_wr_addr), .mem_wr_data_o(mem_wr_data),
    .mem_wr_ready_i(mem_wr_ready),
    .lock_held_i(lock_held), .lock_owner_i(lock_owner), .empty_o(empty)
  );

  assign mem_rd_data = mem[mem_rd_addr];

  initial for (int i = 0; i < 256; i++) mem[i] = 16'hA000 | 16'(i);

  always @(posedge clk) if (mem_wr_valid && mem_wr_ready) mem[mem_wr_addr] <= mem_wr_data;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: every drain leaving this cycle must be the oldest outstanding write
  always @(negedge clk) begin
    if (rst_n && mem_wr_valid && mem_wr_ready) begin
      if (exp_q.size() == 0) chk(0, "R6 unexpected drain", mem_wr_addr, 0);
      else begin
        chk({mem_wr_addr, mem_wr_data} == exp_q[0], "R6 drain order",
            int'({mem_wr_addr, mem_wr_data}), int'(exp_q[0]));
        void'(exp_q.pop_front());
      end
    end
  end

  task automatic drive(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(posedge clk); #1;
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
  endtask

  task automatic idle();
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    drive(2'd1, a, d);
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    exp_q.push_back({a, d});
    chk(1, "R2 write accepted", 1, 1);
    idle();
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
    drive(2'd0, a, '0);
    @(negedge clk);
    chk(req_ready == 1'b1, {tag, " ready"}, req_ready, 1);
    chk(rd_data == e, tag, rd_data, e);
    idle();
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(empty == 1'b1, "R1 empty after reset", empty, 1);
    chk(mem_wr_valid == 1'b0, "R1 no drain after reset", mem_wr_valid, 0);

    // drains stalled: build same-address entries
    do_write(8'h10, 16'h0111);
    do_write(8'h20, 16'h0222);
    do_write(8'h10, 16'h0333);
    @(negedge clk);
    chk(empty == 1'b0, "R11 not empty", empty, 0);
    chk(mem_wr_addr == 8'h10 && mem_wr_data == 16'h0111, "R6 oldest presented", mem_wr_data, 16'h0111);
    repeat (3) @(negedge clk);
    chk(mem_wr_addr == 8'h10 && mem_wr_data == 16'h0111, "R7 drain held", mem_wr_data, 16'h0111);

    do_read(8'h10, 16'h0333, "R4 newest match");
    do_read(8'h20, 16'h0222, "R4 single match");
    drive(2'd0, 8'h30, '0);
    @(negedge clk);
    chk(mem_rd_addr == 8'h30 && mem_rd_en, "R5 memory read addr", mem_rd_addr, 8'h30);
    chk(rd_data == 16'hA030, "R5 memory data", rd_data, 16'hA030);
    idle();

    drive(2'd2, '0, '0);
    @(negedge clk);
    chk(req_ready == 1'b0, "R10 fence stalls", req_ready, 0);
    idle();

    for (int i = 0; i < 5; i++) do_write(8'h40 + 8'(i), 16'h0400 + 16'(i));
    drive(2'd1, 8'h50, 16'h0555);
    @(negedge clk);
    chk(req_ready == 1'b0, "R3 full stalls write", req_ready, 0);
    idle();

    // another thread owns the lock
    @(posedge clk); #1;
    lock_held = 1'b1; lock_owner = 2'(OTHER); mem_wr_ready = 1'b1;
    @(negedge clk);
    chk(mem_wr_valid == 1'b0, "R8 drain blocked", mem_wr_valid, 0);
    drive(2'd0, 8'h20, '0);
    @(negedge clk);
    chk(req_ready == 1'b0, "R8 read blocked", req_ready, 0);
    idle();
    drive(2'd1, 8'h50, 16'h0555);
    @(negedge clk);
    chk(req_ready == 1'b0, "R8 still full while blocked", req_ready, 0);
    idle();

    // this thread owns the lock
    @(posedge clk); #1;
    lock_owner = 2'(SELF);
    @(negedge clk);
    chk(mem_wr_valid == 1'b1, "R9 drain with own lock", mem_wr_valid, 1);
    do_read(8'h20, 16'h0222, "R9 read with own lock");

    @(posedge clk); #1;
    lock_held = 1'b0; lock_owner = '0;
    do_write(8'h50, 16'h0555);
    drive(2'd2, '0, '0);
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    chk(empty == 1'b1, "R10 fence on empty", empty, 1);
    chk(exp_q.size() == 0, "R6 all drained", exp_q.size(), 0);
    idle();
    @(negedge clk);
    chk(empty == 1'b1, "R11 empty after drain", empty, 1);

    do_read(8'h10, 16'h0333, "R5 final memory newest");
    do_read(8'h44, 16'h0404, "R5 final memory tail");
    do_read(8'h50, 16'h0555, "R5 late write in memory");

    done = 1;
    finish_run();
  end
endmodule